// File: doc/BRIEF.md
# Chained Priority Arbiter for a Shared Resource

This block grants one shared resource, such as a single function engine or a single storage array, to one of several requesters that may ask for it at the same time. It is built from identical slices, one per requester. The slices are linked in a fixed priority chain. A slice lower in the chain wins over the slices after it.

All slices also watch one common "held" line. While any slice holds a grant, the line is asserted, and no slice may enter the chain. A late or higher-priority request therefore cannot take over a grant that is already running. It waits until the current user reports that it is done.

A grant is registered. It appears on the clock edge after the cycle in which the request wins, and it stays up until the requester's done pulse is sampled. A request that loses stays pending, and it competes again as soon as the held line clears.

Top module: `shared_grant_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `gnt` is all zeros and `held` is 0.
- R2: When `held` is 0 and at least one `req` bit is 1, `gnt` becomes one-hot on the next rising clock edge.
- R3: When several `req` bits are 1 in a cycle with `held` at 0, the grant goes to the lowest-numbered of them. Bit 0 has the highest priority.
- R4: At most one `gnt` bit is 1 at any time.
- R5: A granted bit stays 1 for as long as its `done` bit is 0. It stays 1 even if its `req` bit drops.
- R6: When `done[i]` is 1 while `gnt[i]` is 1, `gnt[i]` is 0 after the next rising edge.
- R7: While `held` is 1, no `gnt` bit rises. This holds for every request, including one with higher priority than the current holder.
- R8: A request that lost, or that arrived while the resource was held, is granted one cycle after the holder's grant falls. This assumes its `req` bit is still 1 and no lower-numbered request is active.
- R9: `held` is 1 exactly when some `gnt` bit is 1.
- R10: `claim` is 1 combinationally in any cycle where `held` is 0 and some `req` bit is 1. It is 0 whenever `held` is 1.
- R11: A `done` bit whose `gnt` bit is 0 has no effect on `gnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | Request from each requester; bit 0 has the highest priority |
| done | input | N | Completion pulse from each requester |
| gnt | output | N | One-hot grant, registered |
| held | output | 1 | The shared progress line: 1 while any grant is active |
| claim | output | 1 | End of the chain: some slice is competing this cycle |

## Verification
The assertions check four behaviours on every cycle: that grants are mutually exclusive, that a grant persists until its done pulse and then falls, that no grant rises while the line is held, and that a free-bus request goes to the lowest index. Only the bench's scenarios show the rest. These are a loser being served exactly one cycle after release, the ignoring of stray done pulses, the combinational timing of `claim`, and the clearing of a live grant by reset.

// File: rtl/shared_grant_arbiter.sv
module arb_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic done,
  input  logic bus_busy,
  input  logic chain_in,
  output logic chain_out,
  output logic grant
);
  logic owner;
  logic compete;
  logic win;

  assign compete   = req & ~bus_busy;
  assign chain_out = chain_in | compete;
  assign win       = compete & ~chain_in;
  assign grant     = owner;

  always_ff @(posedge clk) begin
    if (!rst_n)              owner <= 1'b0;
    else if (owner && done)  owner <= 1'b0;
    else if (win)            owner <= 1'b1;
  end
endmodule

module shared_grant_arbiter #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] done,
  output logic [N-1:0] gnt,
  output logic         held,
  output logic         claim
);
  logic [N:0] chain;

  assign chain[0] = 1'b0;
  assign held     = |gnt;
  assign claim    = chain[N];

  for (genvar i = 0; i < N; i++) begin : g_slice
    arb_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[i]),
      .done      (done[i]),
      .bus_busy  (held),
      .chain_in  (chain[i]),
      .chain_out (chain[i+1]),
      .grant     (gnt[i])
    );
  end
endmodule

// File: rtl/shared_grant_arbiter_chk.sv
module shared_grant_arbiter_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] done,
  input logic [N-1:0] gnt,
  input logic         held
);
  logic [N-1:0] lowest_req;
  assign lowest_req = req & (~req + 1'b1);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R4

  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & ~done) != '0) |=> ((($past(gnt & ~done)) & ~gnt) == '0)); // R5

  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt & done) != '0) |=> ((($past(gnt & done)) & gnt) == '0)); // R6

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> ((gnt & ~$past(gnt)) == '0)); // R7

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && req != '0) |=> (gnt == $past(lowest_req))); // R3
endmodule

bind shared_grant_arbiter shared_grant_arbiter_chk #(.N(N)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .done  (done),
  .gnt   (gnt),
  .held  (held)
);

// File: tb/sim_shared_grant_arbiter.sv
module sim_shared_grant_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] done = '0;
  logic [N-1:0] gnt;
  logic         held;
  logic         claim;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shared_grant_arbiter #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .done(done),
    .gnt(gnt), .held(held), .claim(claim)
  );

  // {req, done, expected gnt after the edge}
  localparam logic [11:0] VEC [14] = '{
    {4'b0001, 4'b0000, 4'b0001},  // R2
    {4'b0110, 4'b0000, 4'b0001},  // R7 R5
    {4'b0110, 4'b0001, 4'b0000},  // R6
    {4'b0110, 4'b0000, 4'b0010},  // R8 R3
    {4'b0100, 4'b1000, 4'b0010},  // R11
    {4'b0100, 4'b0010, 4'b0000},  // R6
    {4'b0100, 4'b0000, 4'b0100},  // R8
    {4'b0000, 4'b0100, 4'b0000},  // R6
    {4'b1111, 4'b0000, 4'b0001},  // R3
    {4'b1110, 4'b0001, 4'b0000},  // R6
    {4'b1110, 4'b0000, 4'b0010},  // R8 R3
    {4'b1000, 4'b0010, 4'b0000},  // R6
    {4'b1000, 4'b0000, 4'b1000},  // R8
    {4'b0000, 4'b1000, 4'b0000}   // R6
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] d);
    @(negedge clk);
    req = r;
    done = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 gnt in reset", gnt, 0);
    check("R1 held in reset", held, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1 gnt after reset", gnt, 0);

    for (int k = 0; k < 14; k++) begin
      step(VEC[k][11:8], VEC[k][7:4]);
      check($sformatf("R2-R8 vector %0d gnt", k), gnt, VEC[k][3:0]);
      check("R9 held", held, |VEC[k][3:0]);
    end

    step('0, '1);
    check("R11 done while idle", gnt, 0);

    @(negedge clk);
    req = 4'b0100;
    #1;
    check("R10 claim free bus", claim, 1);
    @(posedge clk);
    #1;
    check("R2 grant slot 2", gnt, 4'b0100);
    check("R10 claim while held", claim, 0);

    step(4'b0001, '0);
    check("R7 higher request waits", gnt, 4'b0100);

    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset clears grant", gnt, 0);
    check("R1 reset clears held", held, 0);
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule